// File: doc/BRIEF.md
# ECC Error Log and Fault Injection Unit

This unit sits beside a 64-bit memory that is guarded by an error-correcting code. The codec reports each correctable or uncorrectable error as a one-cycle event. The event carries the failing address and the 64-bit data word. The unit keeps a separate capture bank for each error class. Each bank holds the first failure it sees until software acknowledges it. Each class has a status bit, and an interrupt line is raised for every status bit whose mask bit is clear.

For testing the codec path, software can load a 64-bit flip pattern and a 24-bit countdown. The countdown starts when the count register is written. Once it reaches zero, the pattern is driven to the memory for exactly one write, and then the unit disarms. Everything is reached over a plain 32-bit register bus. The bus has a byte offset, a write strobe and write data, and read data is returned combinationally.

Top module: `ecc_errlog_unit`

## Requirements
- R1: After reset the following values hold:
  - status reads 0;
  - the mask register at 0x08 reads 0x000000C0;
  - ECC control at 0x14 reads 0;
  - the count at 0x74 reads 0;
  - `irq` and `inj_mask` are 0.
- R2: Bit 0 of the ECC control register at 0x14 enables ECC and reads back as written. While it is 0, error events set no status and load no capture register.
- R3: A correctable event sets status bit 6 at 0x04 and captures the failing address, zero-extended, at 0x1C. It also captures the data: bits 31:0 at 0x20 and bits 63:32 at 0x24. An uncorrectable event does the same for status bit 7, with the address at 0x34 and the data at 0x38 (low word) and 0x3C (high word).
- R4: While a status bit is set, further events of that class leave its capture registers unchanged.
- R5: Writing 1 to bit 6 or bit 7 of 0x04 clears that status bit, and writing 0 has no effect. An event in the same cycle as its clear wins: the status bit stays 1 and that event is captured.
- R6: The mask register at 0x08 holds bit 6 (correctable) and bit 7 (uncorrectable), where 1 means masked. Its other bits read 0.
  - Writing 1 to a bit at 0x0C clears that mask bit.
  - Writing 1 to a bit at 0x10 sets that mask bit.
  - All other written bits have no effect.
- R7: `irq` is high exactly when some status bit is set and its mask bit is clear.
- R8: The flip pattern is written and read back as two words: bits 31:0 at 0x4C and bits 63:32 at 0x50.
- R9: Writing 0x74 loads bits 23:0 of the write data into the countdown, ignores bits 31:24, and arms injection. Reading 0x74 returns the current count. The count falls by one per cycle while it is armed and nonzero.
- R10: While armed with a count of zero, `inj_mask` equals the pattern in each cycle where `mem_wr` is high, and is zero otherwise. The first such write disarms the unit, and `inj_mask` then stays 0 until 0x74 is written again.
- R11: Offsets outside the map, including 0x00, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| ce_evt | input | 1 | Correctable error event |
| ue_evt | input | 1 | Uncorrectable error event |
| evt_addr | input | 20 | Failing address of the event |
| evt_data | input | 64 | Failing data of the event |
| mem_wr | input | 1 | Memory write in this cycle |
| inj_mask | output | 64 | Bits to flip on this memory write |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a software clear of a status bit and a fresh error event of the same class. The bench places both on one clock edge. It issues a write-one-to-clear of the uncorrectable bit while an uncorrectable event with a new address arrives. It then reads the status and the capture address. The status bit must still be set, and the address must be the new one. A lost event, or a stale capture, is reported as a failure.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int REG_AW = 8;
    localparam int BUS_W  = 32;
    localparam int CE_BIT = 6;
    localparam int UE_BIT = 7;

    typedef logic [REG_AW-1:0] reg_off_t;

    localparam reg_off_t OFF_ISR    = 8'h04;
    localparam reg_off_t OFF_IMR    = 8'h08;
    localparam reg_off_t OFF_IEN    = 8'h0C;
    localparam reg_off_t OFF_IDS    = 8'h10;
    localparam reg_off_t OFF_ECC    = 8'h14;
    localparam reg_off_t OFF_CE_ADR = 8'h1C;
    localparam reg_off_t OFF_CE_DAT = 8'h20;
    localparam reg_off_t OFF_UE_ADR = 8'h34;
    localparam reg_off_t OFF_UE_DAT = 8'h38;
    localparam reg_off_t OFF_PAT    = 8'h4C;
    localparam reg_off_t OFF_CNT    = 8'h74;

    // index of each error class in the two-bit status and mask vectors
    typedef enum logic [0:0] {
        SRC_CE = 1'b0,
        SRC_UE = 1'b1
    } err_src_e;

    typedef struct packed {
        logic             wr;
        reg_off_t         addr;
        logic [BUS_W-1:0] data;
    } bus_req_t;

    // byte offset of word idx of a multi-word field
    function automatic reg_off_t word_off(reg_off_t base, int idx);
        return base + reg_off_t'(4 * idx);
    endfunction

    // place a {ue, ce} pair at its bus bit positions
    function automatic logic [BUS_W-1:0] place_pair(logic [1:0] pair);
        logic [BUS_W-1:0] v;
        v = '0;
        v[CE_BIT] = pair[SRC_CE];
        v[UE_BIT] = pair[SRC_UE];
        return v;
    endfunction

    // pick the {ue, ce} pair out of a bus word
    function automatic logic [1:0] pick_pair(logic [BUS_W-1:0] w);
        return {w[UE_BIT], w[CE_BIT]};
    endfunction

endpackage

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
    parameter int AW = 20,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ecc_on,
    input  logic          evt,
    input  logic [AW-1:0] evt_addr,
    input  logic [DW-1:0] evt_data,
    input  logic          clr,
    output logic          status,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data
);

    logic hit;
    logic take;

    assign hit  = ecc_on && evt;
    // first failure only, unless the held one is being acknowledged now
    assign take = hit && (!status || clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (hit) begin
            status <= 1'b1;
        end else if (clr) begin
            status <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (take) begin
            cap_addr <= evt_addr;
            cap_data <= evt_data;
        end
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (status && !clr) |=> ($stable(cap_addr) && $stable(cap_data))); // R4

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status && !clr) |=> status); // R5

    AST_EVENT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && ecc_on && evt) |=> (status && cap_addr == $past(evt_addr))); // R5

endmodule

// File: rtl/ecc_irq_ctrl.sv
module ecc_irq_ctrl
    import ecc_log_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  logic       dis_wr,
    input  logic [1:0] wbits,
    input  logic [1:0] status,
    output logic [1:0] mask,
    output logic       irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= 2'b11;
        end else if (en_wr) begin
            mask <= mask & ~wbits;
        end else if (dis_wr) begin
            mask <= mask | wbits;
        end
    end

    assign irq = |(status & ~mask);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        (dis_wr && !en_wr && wbits[SRC_UE]) |=> mask[SRC_UE]); // R6

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
        (en_wr && wbits[SRC_CE]) |=> !mask[SRC_CE]); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b00) |-> !irq); // R7

endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
    import ecc_log_pkg::*;
#(
    parameter int DW = 64,
    parameter int CW = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DW/32-1:0] pat_wr,
    input  logic             cnt_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             mem_wr,
    output logic [DW-1:0]    pattern,
    output logic [CW-1:0]    count,
    output logic [DW-1:0]    inj_mask
);

    localparam int NW = DW / 32;

    logic armed;
    logic fire;

    for (genvar w = 0; w < NW; w++) begin : g_pat
        always_ff @(posedge clk) begin
            if (rst) begin
                pattern[32*w +: 32] <= '0;
            end else if (pat_wr[w]) begin
                pattern[32*w +: 32] <= wdata;
            end
        end
    end

    assign fire = armed && (count == '0) && mem_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            armed <= 1'b0;
        end else if (cnt_wr) begin
            count <= wdata[CW-1:0];
            armed <= 1'b1;
        end else begin
            if (armed && count != '0) begin
                count <= count - 1'b1;
            end
            if (fire) begin
                armed <= 1'b0;
            end
        end
    end

    assign inj_mask = fire ? pattern : '0;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (armed && count != '0 && !cnt_wr) |=> (count == $past(count) - 1'b1)); // R9

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (fire && !cnt_wr) |=> (inj_mask == '0 && !armed)); // R10

    AST_NO_FLIP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !mem_wr |-> (inj_mask == '0)); // R10

endmodule

// File: rtl/ecc_errlog_unit.sv
module ecc_errlog_unit
    import ecc_log_pkg::*;
#(
    parameter int EVT_AW = 20,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ce_evt,
    input  logic              ue_evt,
    input  logic [EVT_AW-1:0] evt_addr,
    input  logic [DATA_W-1:0] evt_data,
    input  logic              mem_wr,
    output logic [DATA_W-1:0] inj_mask,
    output logic              irq
);

    localparam int NW = DATA_W / 32;

    bus_req_t          req;
    logic              ecc_en;
    logic [1:0]        status;
    logic [1:0]        clr;
    logic [1:0]        mask;
    logic [EVT_AW-1:0] ce_addr, ue_addr;
    logic [DATA_W-1:0] ce_data, ue_data;
    logic [DATA_W-1:0] pattern;
    logic [CNT_W-1:0]  count;
    logic [NW-1:0]     pat_wr;

    assign req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    // ECC enable
    always_ff @(posedge clk) begin
        if (rst) begin
            ecc_en <= 1'b0;
        end else if (req.wr && req.addr == OFF_ECC) begin
            ecc_en <= req.data[0];
        end
    end

    assign clr = (req.wr && req.addr == OFF_ISR) ? pick_pair(req.data) : 2'b00;

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            pat_wr[w] = req.wr && (req.addr == word_off(OFF_PAT, w));
        end
    end

    ecc_capture_bank #(.AW(EVT_AW), .DW(DATA_W)) u_ce_bank (
        .clk      (clk),
        .rst      (rst),
        .ecc_on   (ecc_en),
        .evt      (ce_evt),
        .evt_addr (evt_addr),
        .evt_data (evt_data),
        .clr      (clr[SRC_CE]),
        .status   (status[SRC_CE]),
        .cap_addr (ce_addr),
        .cap_data (ce_data)
    );

    ecc_capture_bank #(.AW(EVT_AW), .DW(DATA_W)) u_ue_bank (
        .clk      (clk),
        .rst      (rst),
        .ecc_on   (ecc_en),
        .evt      (ue_evt),
        .evt_addr (evt_addr),
        .evt_data (evt_data),
        .clr      (clr[SRC_UE]),
        .status   (status[SRC_UE]),
        .cap_addr (ue_addr),
        .cap_data (ue_data)
    );

    ecc_irq_ctrl u_irq (
        .clk    (clk),
        .rst    (rst),
        .en_wr  (req.wr && req.addr == OFF_IEN),
        .dis_wr (req.wr && req.addr == OFF_IDS),
        .wbits  (pick_pair(req.data)),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    ecc_inject_ctrl #(.DW(DATA_W), .CW(CNT_W)) u_inj (
        .clk      (clk),
        .rst      (rst),
        .pat_wr   (pat_wr),
        .cnt_wr   (req.wr && req.addr == OFF_CNT),
        .wdata    (req.data),
        .mem_wr   (mem_wr),
        .pattern  (pattern),
        .count    (count),
        .inj_mask (inj_mask)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_ISR:    bus_rdata = place_pair(status);
            OFF_IMR:    bus_rdata = place_pair(mask);
            OFF_ECC:    bus_rdata = {{(BUS_W-1){1'b0}}, ecc_en};
            OFF_CE_ADR: bus_rdata = BUS_W'(ce_addr);
            OFF_UE_ADR: bus_rdata = BUS_W'(ue_addr);
            OFF_CNT:    bus_rdata = BUS_W'(count);
            default:    bus_rdata = '0;
        endcase
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == word_off(OFF_CE_DAT, w)) bus_rdata = ce_data[32*w +: 32];
            if (bus_addr == word_off(OFF_UE_DAT, w)) bus_rdata = ue_data[32*w +: 32];
            if (bus_addr == word_off(OFF_PAT, w))    bus_rdata = pattern[32*w +: 32];
        end
    end

    AST_ECC_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ecc_en && status == 2'b00) |=> (status == 2'b00)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 8'h00) |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/ecc_errlog_unit_bench.sv
module ecc_errlog_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ce_evt = 1'b0;
    logic        ue_evt = 1'b0;
    logic [19:0] evt_addr = '0;
    logic [63:0] evt_data = '0;
    logic        mem_wr = 1'b0;
    logic [63:0] inj_mask;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_errlog_unit u_ecc_errlog_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ce_evt    (ce_evt),
        .ue_evt    (ue_evt),
        .evt_addr  (evt_addr),
        .evt_data  (evt_data),
        .mem_wr    (mem_wr),
        .inj_mask  (inj_mask),
        .irq       (irq)
    );

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'h14, 32'h0000_0001, 8'h14, 32'h0000_0001, 8'd2},  // R2 enable reads back
        '{8'h0C, 32'h0000_0040, 8'h08, 32'h0000_0080, 8'd6},  // R6 unmask CE
        '{8'h0C, 32'h0000_0080, 8'h08, 32'h0000_0000, 8'd6},  // R6 unmask UE
        '{8'h10, 32'h0000_0040, 8'h08, 32'h0000_0040, 8'd6},  // R6 mask CE
        '{8'h0C, 32'h0000_003F, 8'h08, 32'h0000_0040, 8'd6},  // R6 other bits ignored
        '{8'h4C, 32'hDEAD_BEEF, 8'h4C, 32'hDEAD_BEEF, 8'd8},  // R8 low word
        '{8'h50, 32'h0123_4567, 8'h50, 32'h0123_4567, 8'd8},  // R8 high word
        '{8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 8'd11}, // R11 unmapped
        '{8'h74, 32'hAB00_0000, 8'h74, 32'h0000_0000, 8'd9},  // R9 upper bits dropped
        '{8'h10, 32'h0000_00C0, 8'h08, 32'h0000_00C0, 8'd6},  // R6 mask both
        '{8'h04, 32'hFFFF_FFFF, 8'h04, 32'h0000_0000, 8'd5},  // R5 clear idle status
        '{8'h4C, 32'hDEAD_BEEF, 8'h50, 32'h0123_4567, 8'd8}   // R8 word isolation
    };

    localparam logic [63:0] PAT = 64'h0123_4567_DEAD_BEEF;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input bit ce, input bit ue, input logic [19:0] a, input logic [63:0] d);
        @(negedge clk);
        ce_evt = ce;
        ue_evt = ue;
        evt_addr = a;
        evt_data = d;
        @(negedge clk);
        ce_evt = 1'b0;
        ue_evt = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h04, r); check("R1 status", r, 32'h0);
        rd(8'h08, r); check("R1 mask", r, 32'hC0);
        rd(8'h14, r); check("R1 ecc ctrl", r, 32'h0);
        rd(8'h74, r); check("R1 count", r, 32'h0);
        check("R1 irq", irq, 1'b0);
        mem_wr = 1'b1; #1;
        check("R1 inj_mask", inj_mask, 64'h0);
        mem_wr = 1'b0;

        // R2 events ignored while ECC is off
        pulse(1'b1, 1'b1, 20'h0F0F0, 64'h1111_2222_3333_4444);
        rd(8'h04, r); check("R2 status off", r, 32'h0);
        rd(8'h1C, r); check("R2 ce addr off", r, 32'h0);
        rd(8'h38, r); check("R2 ue data off", r, 32'h0);

        // register table
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].waddr, VECS[i].wdata);
            rd(VECS[i].raddr, r);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].exp);
        end

        // R3 correctable capture, R7 masked then unmasked
        pulse(1'b1, 1'b0, 20'h12345, 64'hA5A5_0001_5A5A_0002);
        rd(8'h04, r); check("R3 ce status", r, 32'h40);
        rd(8'h1C, r); check("R3 ce addr", r, 32'h0001_2345);
        rd(8'h20, r); check("R3 ce data low", r, 32'h5A5A_0002);
        rd(8'h24, r); check("R3 ce data high", r, 32'hA5A5_0001);
        check("R7 irq masked", irq, 1'b0);
        wr(8'h0C, 32'h40);
        check("R7 irq unmasked", irq, 1'b1);

        // R4 first failure held
        pulse(1'b1, 1'b0, 20'h00ABC, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h1C, r); check("R4 ce addr held", r, 32'h0001_2345);
        rd(8'h20, r); check("R4 ce data held", r, 32'h5A5A_0002);

        // R3 uncorrectable capture
        pulse(1'b0, 1'b1, 20'h00777, 64'h0BAD_F00D_CAFE_0042);
        rd(8'h04, r); check("R3 both status", r, 32'hC0);
        rd(8'h34, r); check("R3 ue addr", r, 32'h0000_0777);
        rd(8'h38, r); check("R3 ue data low", r, 32'hCAFE_0042);
        rd(8'h3C, r); check("R3 ue data high", r, 32'h0BAD_F00D);

        // R5 write-one-to-clear; R7 irq follows unmasked status only
        wr(8'h04, 32'h40);
        rd(8'h04, r); check("R5 ce cleared", r, 32'h80);
        check("R7 irq ue masked", irq, 1'b0);
        wr(8'h04, 32'h0);
        rd(8'h04, r); check("R5 zero write", r, 32'h80);

        // R5 clear and new event in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h80;
        ue_evt = 1'b1; evt_addr = 20'h0ABCD; evt_data = 64'h1;
        @(negedge clk);
        bus_wr = 1'b0; ue_evt = 1'b0;
        rd(8'h04, r); check("R5 event wins", r, 32'h80);
        rd(8'h34, r); check("R5 new capture", r, 32'h0000_ABCD);
        wr(8'h04, 32'h80);
        rd(8'h04, r); check("R5 final clear", r, 32'h0);

        // R9 / R10 countdown then one-shot injection
        wr(8'h74, 32'hFF00_0003);
        mem_wr = 1'b1;
        rd(8'h74, r); check("R9 count loaded", r, 32'h3);
        check("R10 no flip counting", inj_mask, 64'h0);
        @(negedge clk); rd(8'h74, r); check("R9 count 2", r, 32'h2);
        @(negedge clk); check("R10 no flip at 1", inj_mask, 64'h0);
        @(negedge clk); #1; check("R10 flip at zero", inj_mask, PAT);
        @(negedge clk); #1; check("R10 disarmed", inj_mask, 64'h0);
        mem_wr = 1'b0;

        // R10 armed at zero waits for a write
        wr(8'h74, 32'h0);
        repeat (2) @(negedge clk);
        check("R10 idle without write", inj_mask, 64'h0);
        mem_wr = 1'b1; #1;
        check("R10 flip on write", inj_mask, PAT);
        @(negedge clk); #1;
        check("R10 one write only", inj_mask, 64'h0);
        mem_wr = 1'b0;

        finish_run();
    end

endmodule